// File: doc/BRIEF.md
# Key-Protected Watchdog Interval Timer

An 8-bit up-counter driven by a selectable power-of-two prescaler. It serves either as a watchdog or as a periodic interval timer. In watchdog mode a counter overflow produces a fixed-length pulse on `wdt_ovf_o`. In interval mode the overflow raises a level interrupt request on `irq_o`. In both modes an overflow sets a sticky flag in the control register.

Software reaches the block through a small register bus. Reads are byte-wide and combinational. Writes take effect only as 16-bit accesses whose upper byte carries a key. The counter and the control register each have their own key, so a stray store cannot reload or reconfigure the timer. A system that needs two timers instantiates the module twice; each copy has its own counter and control register.

Top module: `wdt_keyed_timer`

## Requirements
- R1: After reset the counter reads 0x00, the control register reads 0x18, and `wdt_ovf_o` and `irq_o` are low.
- R2: A write with `wr_word_i`=1, `sel_i`=1 and `wdata_i[15:8]`=0x5A loads `wdata_i[7:0]` into the counter at that clock edge.
- R3: A write with `wr_word_i`=1, `sel_i`=0 and `wdata_i[15:8]`=0xA5 loads the control register. The control fields are: bit 6 mode (1 = interval, 0 = watchdog), bit 5 enable, bits 2:0 clock select. Bits 4:3 always read as 1.
- R4: A byte write (`wr_word_i`=0), or a 16-bit write whose upper byte is not the key of the selected register, leaves that register unchanged.
- R5: `rdata_o` returns the control register when `sel_i`=0 and the counter when `sel_i`=1. Control is read as {flag, mode, enable, 2'b11, clock select}.
- R6: While enable is 0 the counter holds its value. The prescaler is cleared, so counting restarts in phase when the timer is enabled again.
- R7: While enabled with clock select k, the counter increments once every 2^k clocks. The first increment comes at the 2^k-th edge after enable takes effect.
- R8: An increment from 0xFF wraps to 0x00 and sets the flag (bit 7). The flag stays set until a control write with bit 7 = 0. Writing 1 to the flag has no effect. An overflow in the same cycle as a clearing write leaves the flag set.
- R9: In watchdog mode an overflow drives `wdt_ovf_o` high for exactly 4 clocks (PULSE_LEN), starting the cycle after the overflow edge. The counter keeps running.
- R10: `irq_o` equals the flag while the mode is interval and is low in watchdog mode. An overflow in interval mode produces no pulse on `wdt_ovf_o`.
- R11: A valid counter write in the same cycle as a prescaler tick takes priority. No increment or overflow happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| wr_word_i | input | 1 | 1 = 16-bit write, 0 = byte write |
| sel_i | input | 1 | Register select: 0 control, 1 counter |
| wdata_i | input | 16 | Write data: key in the upper byte, value in the lower byte |
| rdata_o | output | 8 | Byte read data of the selected register |
| wdt_ovf_o | output | 1 | Watchdog overflow pulse |
| irq_o | output | 1 | Interval interrupt request (level) |

## Verification
The hardest case to reach is a collision at the overflow edge: a flag-clearing control write, or a counter reload, arriving in the very cycle in which the counter wraps. The stimulus reaches it with clock select 0, where the counter advances every clock. It loads the counter at a known value and issues the colliding write a computed number of cycles later. A behavioural model that runs alongside the design resolves both priorities, and every clock it compares the read data and both outputs with the model.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CKS_W = 3;
  localparam logic [7:0] KEY_CNT = 8'h5A;
  localparam logic [7:0] KEY_CTL = 8'hA5;

  typedef enum logic {SEL_CTL = 1'b0, SEL_CNT = 1'b1} sel_e;

  typedef struct packed {
    logic             flag;
    logic             mode;   // 1 = interval
    logic             en;
    logic [CKS_W-1:0] cks;
  } ctl_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int CKS_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CKS_W-1:0] cks_i,
  output logic             tick_o
);
  localparam int PRE_W = (1 << CKS_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pre_q <= '0;
    else if (!en_i) pre_q <= '0;
    else            pre_q <= pre_q + 1'b1;
  end

  // tap k fires when the low k bits are all ones
  always_comb begin
    mask   = (PRE_W'(1) << cks_i) - PRE_W'(1);
    tick_o = en_i && ((pre_q & mask) == mask);
  end

  p_pre_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (pre_q == '0));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wr_i)   cnt_q <= wdata_i;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
  assign ovf_o = tick_i && !wr_i && (&cnt_q);

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_i) |=> $stable(cnt_q));
  p_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> (cnt_q == '0));
  p_wr_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (cnt_q == $past(wdata_i)));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic pulse_o
);
  localparam int LEN_W = $clog2(LEN + 1);

  logic [LEN_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             left_q <= '0;
    else if (fire_i)         left_q <= LEN_W'(LEN);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign pulse_o = (left_q != '0);

  p_pulse_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> pulse_o);
endmodule

// File: rtl/wdt_keyed_timer.sv
module wdt_keyed_timer #(
  parameter int         CNT_W     = 8,
  parameter int         PULSE_LEN = 4,
  parameter logic [7:0] KEY_CNT   = wdt_pkg::KEY_CNT,
  parameter logic [7:0] KEY_CTL   = wdt_pkg::KEY_CTL
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        wr_word_i,
  input  logic        sel_i,
  input  logic [15:0] wdata_i,
  output logic [7:0]  rdata_o,
  output logic        wdt_ovf_o,
  output logic        irq_o
);
  import wdt_pkg::*;

  ctl_t             ctl_q;
  logic             tick;
  logic             ovf_evt;
  logic             cnt_wr;
  logic             ctl_wr;
  logic [CNT_W-1:0] cnt;

  assign cnt_wr = wr_en_i && wr_word_i && (sel_i == SEL_CNT) && (wdata_i[15:8] == KEY_CNT);
  assign ctl_wr = wr_en_i && wr_word_i && (sel_i == SEL_CTL) && (wdata_i[15:8] == KEY_CTL);

  wdt_prescaler #(.CKS_W(CKS_W)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (ctl_q.en),
    .cks_i (ctl_q.cks),
    .tick_o(tick)
  );

  wdt_counter #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .wr_i   (cnt_wr),
    .wdata_i(wdata_i[CNT_W-1:0]),
    .cnt_o  (cnt),
    .ovf_o  (ovf_evt)
  );

  wdt_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (ovf_evt && !ctl_q.mode),
    .pulse_o(wdt_ovf_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else begin
      if (ctl_wr) begin
        ctl_q.mode <= wdata_i[6];
        ctl_q.en   <= wdata_i[5];
        ctl_q.cks  <= wdata_i[CKS_W-1:0];
      end
      // overflow set beats software clear; software cannot set
      if (ovf_evt)                   ctl_q.flag <= 1'b1;
      else if (ctl_wr && !wdata_i[7]) ctl_q.flag <= 1'b0;
    end
  end

  always_comb begin
    if (sel_i == SEL_CNT) rdata_o = 8'(cnt);
    else rdata_o = {ctl_q.flag, ctl_q.mode, ctl_q.en, 2'b11, ctl_q.cks};
  end

  assign irq_o = ctl_q.flag && ctl_q.mode;

  p_flag_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt |=> ctl_q.flag);
  p_ctl_ignore_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_i == SEL_CTL && (!wr_word_i || wdata_i[15:8] != KEY_CTL) && !ovf_evt)
    |=> $stable(ctl_q));
  p_cnt_ignore_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_i == SEL_CNT && (!wr_word_i || wdata_i[15:8] != KEY_CNT) && !tick)
    |=> $stable(cnt));
  p_no_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q.mode && !wdt_ovf_o) |=> !wdt_ovf_o);
endmodule

// File: tb/wdt_keyed_timer_test.sv
module wdt_keyed_timer_test;
  localparam int PULSE = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_word = 1'b0;
  logic        sel = 1'b0;
  logic [15:0] wdata = '0;
  logic [7:0]  rdata;
  logic        ovf_o;
  logic        irq;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";

  // reference model state
  int m_cnt, m_flag, m_mode, m_en, m_cks, m_pre, m_pulse;

  always #10 clk = ~clk;

  wdt_keyed_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_word_i(wr_word),
    .sel_i(sel), .wdata_i(wdata), .rdata_o(rdata), .wdt_ovf_o(ovf_o), .irq_o(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_flag = 0; m_mode = 0; m_en = 0; m_cks = 0; m_pre = 0; m_pulse = 0;
    end else begin
      int per;
      bit tick, cw, kw, ov;
      per  = 1 << m_cks;
      tick = (m_en != 0) && ((m_pre % per) == per - 1);
      cw   = wr_en && wr_word && sel && (wdata[15:8] == 8'h5A);
      kw   = wr_en && wr_word && !sel && (wdata[15:8] == 8'hA5);
      ov   = tick && !cw && (m_cnt == 255);
      if (ov && m_mode == 0) m_pulse = PULSE;
      else if (m_pulse > 0) m_pulse = m_pulse - 1;
      m_pre = (m_en != 0) ? (m_pre + 1) % 256 : 0;
      if (cw) m_cnt = int'(wdata[7:0]);
      else if (tick) m_cnt = (m_cnt + 1) % 256;
      if (ov) m_flag = 1;
      else if (kw && !wdata[7]) m_flag = 0;
      if (kw) begin
        m_mode = int'(wdata[6]); m_en = int'(wdata[5]); m_cks = int'(wdata[2:0]);
      end
    end
  end

  function automatic int exp_rd(bit s);
    if (s) return m_cnt;
    return (m_flag << 7) | (m_mode << 6) | (m_en << 5) | 8'h18 | m_cks;
  endfunction

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // per-clock comparison at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_req, int'(rdata), exp_rd(sel), sel ? "counter read" : "control read");
      chk(cur_req, int'(ovf_o), (m_pulse != 0) ? 1 : 0, "wdt_ovf_o");
      chk(cur_req, int'(irq), (m_flag != 0 && m_mode != 0) ? 1 : 0, "irq_o");
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #2;
      wr_en = 1'b0;
    end
  endtask

  task automatic wr(bit s, bit word, logic [15:0] d);
    @(negedge clk); #2;
    wr_en = 1'b1; wr_word = word; sel = s; wdata = d;
    @(negedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic look(bit s);
    @(negedge clk); #2;
    sel = s;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("R1", int'(rdata), 8'h18, "reset control");
    chk("R1", int'(ovf_o), 0, "reset ovf");
    chk("R1", int'(irq), 0, "reset irq");
    #2 rst_n = 1'b1;
    look(1);
    @(negedge clk);
    chk("R1", int'(rdata), 8'h00, "reset counter");

    cur_req = "R4";
    wr(1, 1'b0, 16'h5A77);   // byte write
    wr(1, 1'b1, 16'h5B77);   // wrong key
    wr(0, 1'b1, 16'h5A3F);   // counter key at control
    wr(0, 1'b0, 16'hA53F);   // byte write at control
    look(1); idle(2);
    look(0); idle(2);
    chk("R4", int'(rdata), 8'h18, "control after ignored writes");

    cur_req = "R2";
    wr(1, 1'b1, 16'h5A37);
    look(1); idle(1);
    chk("R2", int'(rdata), 8'h37, "counter load");

    cur_req = "R3";
    wr(0, 1'b1, 16'hA520);   // enable, watchdog, cks 0
    look(0); idle(1);
    cur_req = "R5";
    look(1); idle(3);
    cur_req = "R7";
    idle(20);
    wr(0, 1'b1, 16'hA523);   // cks 3
    look(1); idle(60);
    wr(0, 1'b1, 16'hA526);   // cks 6
    idle(200);

    cur_req = "R6";
    wr(0, 1'b1, 16'hA506);
    look(1); idle(40);
    wr(0, 1'b1, 16'hA522);   // re-enable, prescaler restarts in phase
    idle(30);

    cur_req = "R9";
    wr(1, 1'b1, 16'h5AFC);
    wr(0, 1'b1, 16'hA521);   // watchdog, cks 1
    look(1); idle(30);
    look(0); idle(2);
    chk("R8", int'(rdata[7]), 1, "flag after overflow");

    cur_req = "R8";
    wr(0, 1'b1, 16'hA5A0);   // writing 1 to flag keeps it
    idle(2);
    wr(0, 1'b1, 16'hA520);   // clear
    idle(2);
    chk("R8", int'(rdata[7]), 0, "flag cleared");
    // collision: clear write on the overflow edge (cks 0)
    wr(1, 1'b1, 16'h5AFE);   // counter FE, FF next, wrap next
    @(negedge clk); #2;
    wr_en = 1'b1; wr_word = 1'b1; sel = 1'b0; wdata = 16'hA520;
    @(negedge clk); #2;
    wr_en = 1'b0;
    idle(2);
    chk("R8", int'(rdata[7]), 1, "set beats clear");
    wr(0, 1'b1, 16'hA520);
    idle(2);

    cur_req = "R10";
    wr(0, 1'b1, 16'hA560);   // interval, enable, cks 0
    wr(1, 1'b1, 16'h5AF0);
    look(1); idle(30);
    chk("R10", int'(irq), 1, "irq level");
    chk("R10", int'(ovf_o), 0, "no pulse in interval");
    wr(0, 1'b1, 16'hA520);   // back to watchdog: irq masked, flag kept
    idle(2);
    chk("R10", int'(irq), 0, "irq low in watchdog mode");
    wr(0, 1'b1, 16'hA500);

    cur_req = "R11";
    wr(0, 1'b1, 16'hA520);
    wr(1, 1'b1, 16'h5AFE);
    @(negedge clk); #2;      // counter now FF, tick each clock
    wr_en = 1'b1; wr_word = 1'b1; sel = 1'b1; wdata = 16'h5A10;
    @(negedge clk); #2;
    wr_en = 1'b0;
    chk("R11", int'(rdata), 8'h10, "write wins over wrap");
    idle(8);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule